// File: doc/BRIEF.md
# I2C Master Byte-Command Sequencer

This block sits between a queue of per-byte command words and a bit-level I2C engine. For every command it decides which bus phases the engine must run: a START followed by the address byte(s), a RESTART with a fresh address, the data byte itself (write or read), and an optional trailing STOP. It tracks whether it still owns the bus and which direction the last addressing used, so that a RESTART appears only where the direction flips or the command forces one. Bytes read from the bus leave through a receive stream.

The target register selects 7-bit or 10-bit addressing and two special modes: a general call (broadcast address, writes only) and a START byte preamble. Protocol errors, missing acknowledges, lost arbitration and a software abort request all end in an abort state with a one-hot cause in an abort-source vector. While aborted, the block accepts and drops every queued command, which keeps the upstream queue drained, until software clears the abort.

Command stream: a word moves when `cmd_valid` and `cmd_ready` are both high at a clock edge; `cmd_ready` may depend on `cmd_data`. Receive stream: `rx_valid` stays high with `rx_data` unchanged until `rx_ready` is seen high, and no further phase is requested while a read byte waits. Engine handshake: `ph_valid` with `ph_kind`/`ph_byte` is held steady until a one-cycle `ph_done`, which carries `ph_ack`, `ph_arb_lost` and `ph_rdata`.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word carries data in bits 7:0, read (1) or write (0) in bit 8, STOP-after in bit 9 and force-RESTART in bit 10. Phase kinds on `ph_kind` are 1 START, 2 address byte, 3 RESTART, 4 write, 5 read, 6 STOP. With the bus not owned, a command runs START, then the 7-bit address byte {addr[6:0], rw}, then its data phase. The target register (address in bits 9:0, special-mode select in bit 10, special enable in bit 11, 10-bit mode in bit 12) resets to 0x055 and loads `tar_wdata` on `tar_we`.
- R2: While the bus is owned, a command whose direction differs from the previous addressing, or whose force-RESTART bit is set while `restart_en` is high, is preceded by RESTART and a new address byte; otherwise only its data phase runs.
- R3: A command with the STOP bit ends with a STOP phase and the next command starts again with START; a command without it issues no STOP, however long no further command arrives.
- R4: Each read command runs exactly one read phase; the byte from `ph_rdata` leaves on the receive stream and is held until accepted.
- R5: With bit 12 set and bit 11 clear, addressing is {11110, addr[9:8], 0} then addr[7:0]; a read adds RESTART and {11110, addr[9:8], 1}.
- R6: With `restart_en` low, a 10-bit read or a direction change on an owned bus aborts with source bit 10, and a START-byte command aborts with source bit 9.
- R7: Bits 11:10 = 10 select general call: the address byte is 0x00; a read command aborts with source bit 5; no acknowledge on the 0x00 byte aborts with source bit 4.
- R8: Bits 11:10 = 11 select a START-byte preamble: START, address-kind byte 0x01, then RESTART and normal addressing; an acknowledge on the 0x01 byte aborts with source bit 7.
- R9: A missing acknowledge aborts and issues STOP with source bit 0 (7-bit address), bit 1 (first or third 10-bit byte), bit 2 (second 10-bit byte) or bit 3 (write data).
- R10: Lost arbitration on any phase other than STOP aborts with source bit 12 and no further phase, STOP included.
- R11: A pulse on `abort_req` raises `abort_pending` on the next edge; once the current command is finished a STOP is issued if the bus is owned, source bit 16 is set, and `abort_pending` falls when that STOP completes.
- R12: While `abrt_src` is non-zero, commands are accepted and dropped with no phase requested; a pulse on `abort_clr` zeroes `abrt_src` and normal sequencing resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tar_we | input | 1 | Load target register |
| tar_wdata | input | 13 | Target register value |
| restart_en | input | 1 | RESTART generation allowed |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word taken |
| cmd_data | input | 11 | Command word |
| rx_valid | output | 1 | Read byte valid |
| rx_ready | input | 1 | Read byte accepted |
| rx_data | output | 8 | Read byte |
| abort_req | input | 1 | Software abort pulse |
| abort_clr | input | 1 | Leave the abort state |
| abort_pending | output | 1 | Software abort not yet completed |
| abrt_src | output | 17 | One-hot abort cause |
| ph_valid | output | 1 | Phase request to bit engine |
| ph_kind | output | 3 | Requested phase kind |
| ph_byte | output | 8 | Byte for address or write phases |
| ph_done | input | 1 | Phase finished (one cycle) |
| ph_ack | input | 1 | Acknowledge seen in the phase |
| ph_arb_lost | input | 1 | Arbitration lost in the phase |
| ph_rdata | input | 8 | Byte received in a read phase |

## Verification
A new phase request appears on the edge that registers the previous `ph_done`, and an abort cause lands in `abrt_src` on that same edge, while `abort_pending` rises one edge after the `abort_req` pulse. The bench engine model logs each phase when it completes, so every scenario compares the full ordered phase log and the received bytes only after a fixed settle window that exceeds the longest sequence. Status outputs are sampled on falling edges, half a period after the edge that updates them, and hold-type checks (receive back-pressure, pending abort) are taken at a chosen cycle inside the window where the value must already be stable.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CMD_W  = 11;
  localparam int DATA_W = 8;
  localparam int TAR_W  = 13;
  localparam int SRC_W  = 17;
  localparam logic [TAR_W-1:0] TAR_RESET = 13'h055;

  // command word fields
  localparam int CB_RD   = 8;
  localparam int CB_STOP = 9;
  localparam int CB_RS   = 10;

  // target register fields
  localparam int TB_SEL  = 10;
  localparam int TB_SPEC = 11;
  localparam int TB_A10  = 12;

  // abort cause positions
  localparam int AS_ADDR7   = 0;
  localparam int AS_A10_1   = 1;
  localparam int AS_A10_2   = 2;
  localparam int AS_DATA    = 3;
  localparam int AS_GC_NACK = 4;
  localparam int AS_GC_RD   = 5;
  localparam int AS_SB_ACK  = 7;
  localparam int AS_NORS_SB = 9;
  localparam int AS_NORS_10 = 10;
  localparam int AS_ARB     = 12;
  localparam int AS_USER    = 16;

  typedef enum logic [2:0] {
    PH_NONE = 3'd0, PH_START = 3'd1, PH_ADDR = 3'd2, PH_RESTART = 3'd3,
    PH_WRITE = 3'd4, PH_READ = 3'd5, PH_STOP = 3'd6
  } ph_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SB, S_RESTART, S_ADDR1, S_ADDR2, S_RS10, S_ADDR3,
    S_DATA, S_RXPUSH, S_STOP, S_FLUSH
  } seq_state_t;
endpackage

// File: rtl/i2c_seq_tar_reg.sv
module i2c_seq_tar_reg #(
  parameter int W = 13,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (we) q <= wdata;
  end

  AST_TAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R1
endmodule

// File: rtl/i2c_seq_addr_plan.sv
module i2c_seq_addr_plan import i2c_seq_pkg::*; (
  input  logic [TAR_W-1:0]  tar,
  input  logic              rd,
  output logic              is_gc,
  output logic              is_sb,
  output logic              is10,
  output logic [DATA_W-1:0] a1_byte,
  output logic [DATA_W-1:0] a2_byte,
  output logic [DATA_W-1:0] a3_byte,
  output logic [SRC_W-1:0]  a1_src
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    is_gc   = tar[TB_SPEC] && !tar[TB_SEL];
    is_sb   = tar[TB_SPEC] &&  tar[TB_SEL];
    is10    = tar[TB_A10]  && !is_gc;
    a2_byte = tar[7:0];
    a3_byte = {TEN_PREFIX, tar[9:8], 1'b1};
    a1_src  = '0;
    if (is_gc) begin
      a1_byte            = '0;
      a1_src[AS_GC_NACK] = 1'b1;
    end else if (is10) begin
      a1_byte          = {TEN_PREFIX, tar[9:8], 1'b0};
      a1_src[AS_A10_1] = 1'b1;
    end else begin
      a1_byte          = {tar[6:0], rd};
      a1_src[AS_ADDR7] = 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq import i2c_seq_pkg::*; #(
  parameter logic [TAR_W-1:0] TAR_INIT = TAR_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tar_we,
  input  logic [TAR_W-1:0]  tar_wdata,
  input  logic              restart_en,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              abort_req,
  input  logic              abort_clr,
  output logic              abort_pending,
  output logic [SRC_W-1:0]  abrt_src,
  output logic              ph_valid,
  output logic [2:0]        ph_kind,
  output logic [DATA_W-1:0] ph_byte,
  input  logic              ph_done,
  input  logic              ph_ack,
  input  logic              ph_arb_lost,
  input  logic [DATA_W-1:0] ph_rdata
);
  seq_state_t          state;
  logic [CB_RS-1:0]    cur;
  logic                held, last_dir, pend;
  logic [DATA_W-1:0]   rbuf;
  logic [SRC_W-1:0]    abrt, err;
  logic [TAR_W-1:0]    tar;
  logic                is_gc, is_sb, is10, plan_rd;
  logic [DATA_W-1:0]   a1_byte, a2_byte, a3_byte;
  logic [SRC_W-1:0]    a1_src;
  logic                in_rd, dirchg, need_addr;
  seq_state_t          post;

  i2c_seq_tar_reg #(.W(TAR_W), .INIT(TAR_INIT)) u_tar (
    .clk(clk), .rst_n(rst_n), .we(tar_we), .wdata(tar_wdata), .q(tar));

  assign plan_rd = (state == S_IDLE) ? cmd_data[CB_RD] : cur[CB_RD];

  i2c_seq_addr_plan u_plan (
    .tar(tar), .rd(plan_rd), .is_gc(is_gc), .is_sb(is_sb), .is10(is10),
    .a1_byte(a1_byte), .a2_byte(a2_byte), .a3_byte(a3_byte), .a1_src(a1_src));

  // decision for the command at the head of the stream
  always_comb begin
    in_rd     = cmd_data[CB_RD];
    dirchg    = held && (in_rd != last_dir);
    need_addr = !held || dirchg || (cmd_data[CB_RS] && restart_en);
    err       = '0;
    if (is_gc && in_rd)
      err[AS_GC_RD] = 1'b1;
    else if (is_sb && !held && !restart_en)
      err[AS_NORS_SB] = 1'b1;
    else if (!restart_en && (dirchg || (is10 && in_rd && need_addr)))
      err[AS_NORS_10] = 1'b1;
  end

  assign post      = cur[CB_STOP] ? S_STOP : S_IDLE;
  assign cmd_ready = (state == S_IDLE && !pend && err == '0) || state == S_FLUSH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      held     <= 1'b0;
      last_dir <= 1'b0;
      rbuf     <= '0;
      abrt     <= '0;
      pend     <= 1'b0;
    end else begin
      if (abort_req && state != S_FLUSH) pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (pend) begin
            abrt[AS_USER] <= 1'b1;
            state         <= held ? S_STOP : S_FLUSH;
          end else if (cmd_valid) begin
            if (err != '0) begin
              abrt  <= err;
              state <= held ? S_STOP : S_FLUSH;
            end else begin
              cur      <= cmd_data[CB_RS-1:0];
              last_dir <= in_rd;
              state    <= !held ? S_START : (need_addr ? S_RESTART : S_DATA);
            end
          end
        end
        S_FLUSH: begin
          pend <= 1'b0;
          if (abort_clr) begin
            abrt  <= '0;
            state <= S_IDLE;
          end
        end
        S_RXPUSH: if (rx_ready) state <= post;
        default: if (ph_done) begin
          if (ph_arb_lost && state != S_STOP) begin
            abrt[AS_ARB] <= 1'b1;
            held         <= 1'b0;
            state        <= S_FLUSH;
          end else begin
            case (state)
              S_START: begin
                held  <= 1'b1;
                state <= is_sb ? S_SB : S_ADDR1;
              end
              S_SB:
                if (ph_ack) begin abrt[AS_SB_ACK] <= 1'b1; state <= S_STOP; end
                else state <= S_RESTART;
              S_RESTART: state <= S_ADDR1;
              S_ADDR1:
                if (!ph_ack) begin abrt <= a1_src; state <= S_STOP; end
                else state <= is10 ? S_ADDR2 : S_DATA;
              S_ADDR2:
                if (!ph_ack) begin abrt[AS_A10_2] <= 1'b1; state <= S_STOP; end
                else state <= cur[CB_RD] ? S_RS10 : S_DATA;
              S_RS10: state <= S_ADDR3;
              S_ADDR3:
                if (!ph_ack) begin abrt[AS_A10_1] <= 1'b1; state <= S_STOP; end
                else state <= S_DATA;
              S_DATA:
                if (cur[CB_RD]) begin
                  rbuf  <= ph_rdata;
                  state <= S_RXPUSH;
                end else if (!ph_ack) begin
                  abrt[AS_DATA] <= 1'b1;
                  state         <= S_STOP;
                end else state <= post;
              S_STOP: begin
                held <= 1'b0;
                if (abrt != '0 || pend) begin
                  if (abrt == '0) abrt[AS_USER] <= 1'b1;
                  pend  <= 1'b0;
                  state <= S_FLUSH;
                end else state <= S_IDLE;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // phase request decode
  always_comb begin
    ph_kind = PH_NONE;
    ph_byte = '0;
    case (state)
      S_START:           ph_kind = PH_START;
      S_RESTART, S_RS10: ph_kind = PH_RESTART;
      S_SB:    begin ph_kind = PH_ADDR; ph_byte = 8'h01;   end
      S_ADDR1: begin ph_kind = PH_ADDR; ph_byte = a1_byte; end
      S_ADDR2: begin ph_kind = PH_ADDR; ph_byte = a2_byte; end
      S_ADDR3: begin ph_kind = PH_ADDR; ph_byte = a3_byte; end
      S_DATA:  begin
        ph_kind = cur[CB_RD] ? PH_READ : PH_WRITE;
        ph_byte = cur[DATA_W-1:0];
      end
      S_STOP:            ph_kind = PH_STOP;
      default:           ph_kind = PH_NONE;
    endcase
  end

  assign ph_valid      = (ph_kind != PH_NONE);
  assign rx_valid      = (state == S_RXPUSH);
  assign rx_data       = rbuf;
  assign abrt_src      = abrt;
  assign abort_pending = pend;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_done) |=> (ph_valid && $stable(ph_kind) && $stable(ph_byte))); // R1
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R4
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(abrt_src)); // R9
  AST_ONLY_STOP_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (abrt_src != '0 && ph_valid) |-> (ph_kind == PH_STOP)); // R12
  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_pending) |-> (abrt_src != '0)); // R11
  AST_TAKE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ph_valid); // R12
endmodule

// File: tb/test_i2c_cmd_seq.sv
`timescale 1ns/1ps
module test_i2c_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tar_we = 1'b0;
  logic [12:0] tar_wdata = '0;
  logic        restart_en = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [10:0] cmd_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_data;
  logic        abort_req = 1'b0;
  logic        abort_clr = 1'b0;
  logic        abort_pending;
  logic [16:0] abrt_src;
  logic        ph_valid;
  logic [2:0]  ph_kind;
  logic [7:0]  ph_byte;
  logic        ph_done;
  logic        ph_ack;
  logic        ph_arb_lost;
  logic [7:0]  ph_rdata;

  int tests = 0, failed = 0;
  int nack_at = 0, arb_at = 0;
  logic [10:0] obs [64];
  logic [10:0] expv [64];
  logic [7:0]  rxl [16];
  logic [7:0]  erx [16];
  int n_obs, n_exp, n_rx, n_erx, cnt;

  always #5 clk = ~clk;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk(clk), .rst_n(rst_n), .tar_we(tar_we), .tar_wdata(tar_wdata),
    .restart_en(restart_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .abort_req(abort_req), .abort_clr(abort_clr),
    .abort_pending(abort_pending), .abrt_src(abrt_src), .ph_valid(ph_valid),
    .ph_kind(ph_kind), .ph_byte(ph_byte), .ph_done(ph_done), .ph_ack(ph_ack),
    .ph_arb_lost(ph_arb_lost), .ph_rdata(ph_rdata));

  // bit-engine model: completes each phase three cycles after it is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      ph_done <= 1'b0; ph_ack <= 1'b1; ph_arb_lost <= 1'b0; ph_rdata <= '0;
      cnt <= 0; n_obs <= 0;
    end else begin
      ph_done <= 1'b0;
      if (ph_valid && !ph_done) begin
        if (cnt == 2) begin
          ph_done     <= 1'b1;
          cnt         <= 0;
          ph_ack      <= (n_obs + 1 != nack_at);
          ph_arb_lost <= (n_obs + 1 == arb_at);
          ph_rdata    <= 8'h5A ^ 8'(n_obs);
          obs[n_obs]  <= {ph_kind, (ph_kind == 3'd5) ? 8'h00 : ph_byte};
          n_obs       <= n_obs + 1;
        end else cnt <= cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) n_rx <= 0;
    else if (rx_valid && rx_ready) begin
      rxl[n_rx] <= rx_data;
      n_rx      <= n_rx + 1;
    end
  end

  task automatic rst_scn(input logic ren);
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; abort_req = 1'b0; abort_clr = 1'b0;
    tar_we = 1'b0; nack_at = 0; arb_at = 0; rx_ready = 1'b1; restart_en = ren;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; n_exp = 0; n_erx = 0;
    @(negedge clk);
  endtask

  task automatic set_tar(input logic [12:0] v);
    @(negedge clk); tar_we = 1'b1; tar_wdata = v;
    @(negedge clk); tar_we = 1'b0;
  endtask

  task automatic push(input logic [10:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = c;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic ex(input logic [2:0] k, input logic [7:0] b);
    expv[n_exp] = {k, b}; n_exp++;
  endtask

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (a !== e) begin
      failed++;
      $display("FAIL %s: got %0h expected %0h", r, a, e);
    end
  endtask

  task automatic chk_log(input string r);
    logic ok;
    int bad;
    ok = (n_obs == n_exp); bad = -1;
    for (int i = 0; i < n_exp && i < 64; i++)
      if (ok && obs[i] !== expv[i]) begin ok = 1'b0; bad = i; end
    tests++;
    if (!ok) begin
      failed++;
      if (bad < 0) $display("FAIL %s: phase count got %0d expected %0d", r, n_obs, n_exp);
      else $display("FAIL %s: phase %0d got %0h expected %0h", r, bad, obs[bad], expv[bad]);
    end
  endtask

  task automatic chk_rx(input string r);
    logic ok;
    ok = (n_rx == n_erx);
    for (int i = 0; i < n_erx && i < 16; i++) if (rxl[i] !== erx[i]) ok = 1'b0;
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: rx count %0d first %0h expected count %0d first %0h",
               r, n_rx, rxl[0], n_erx, erx[0]);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0;
  endtask

  initial begin
    #1_500_000;
    failed++;
    $display("FAIL watchdog: got running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic held_m, last_m, rd, rs, st;
    logic [6:0] addr;
    logic [10:0] cw [2];

    // reset state and default target address 0x055
    rst_scn(1'b1);
    chk("R1 reset ph_valid", ph_valid, 0);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset abrt_src", abrt_src, 0);
    chk("R11 reset abort_pending", abort_pending, 0);
    chk("R1 reset cmd_ready", cmd_ready, 1);
    push(11'h2C3);
    settle();
    ex(1, 0); ex(2, 8'hAA); ex(4, 8'hC3); ex(6, 0);
    chk_log("R1 default target");

    // sweep all direction / force-restart / stop combinations of two commands
    for (int c = 0; c < 64; c++) begin
      rst_scn(1'b1);
      addr = 7'((c * 37 + 5) & 127);
      set_tar({6'd0, addr});
      cw[0] = {c[1], c[2], c[0], 8'(c)};
      cw[1] = {c[4], c[5], c[3], ~8'(c)};
      push(cw[0]); push(cw[1]);
      settle();
      held_m = 1'b0; last_m = 1'b0;
      for (int j = 0; j < 2; j++) begin
        rd = cw[j][8]; st = cw[j][9]; rs = cw[j][10];
        if (!held_m) begin ex(1, 0); ex(2, {addr, rd}); held_m = 1'b1; end
        else if (rd != last_m || rs) begin ex(3, 0); ex(2, {addr, rd}); end
        last_m = rd;
        if (rd) begin ex(5, 0); erx[n_erx] = 8'h5A ^ 8'(n_exp - 1); n_erx++; end
        else ex(4, cw[j][7:0]);
        if (st) begin ex(6, 0); held_m = 1'b0; end
      end
      chk_log("R2 R3 R4 sweep phases");
      chk_rx("R4 sweep read data");
      chk("R2 sweep no abort", abrt_src, 0);
    end

    // no STOP while idle with stop bit clear
    rst_scn(1'b1); set_tar(13'h012);
    push(11'h011); repeat (300) @(negedge clk);
    ex(1, 0); ex(2, 8'h24); ex(4, 8'h11);
    chk_log("R3 no stop when queue empty");

    // 10-bit write and read
    rst_scn(1'b1); set_tar(13'h12A5);
    push(11'h23C); settle();
    ex(1, 0); ex(2, 8'hF4); ex(2, 8'hA5); ex(4, 8'h3C); ex(6, 0);
    chk_log("R5 ten-bit write");
    rst_scn(1'b1); set_tar(13'h12A5);
    push(11'h300); settle();
    ex(1, 0); ex(2, 8'hF4); ex(2, 8'hA5); ex(3, 0); ex(2, 8'hF5); ex(5, 0); ex(6, 0);
    erx[0] = 8'h5A ^ 8'd5; n_erx = 1;
    chk_log("R5 ten-bit read"); chk_rx("R5 ten-bit read data");

    // restart disabled cases
    rst_scn(1'b0); set_tar(13'h12A5);
    push(11'h300); settle();
    chk_log("R6 ten-bit read no phases"); chk("R6 ten-bit read cause", abrt_src, 17'h00400);
    rst_scn(1'b0); set_tar(13'h0012);
    push(11'h055); push(11'h300); settle();
    ex(1, 0); ex(2, 8'h24); ex(4, 8'h55); ex(6, 0);
    chk_log("R6 dir change stop"); chk("R6 dir change cause", abrt_src, 17'h00400);
    rst_scn(1'b0); set_tar(13'h0C33);
    push(11'h201); settle();
    chk_log("R6 start byte no phases"); chk("R6 start byte cause", abrt_src, 17'h00200);

    // general call
    rst_scn(1'b1); set_tar(13'h0800);
    push(11'h277); settle();
    ex(1, 0); ex(2, 8'h00); ex(4, 8'h77); ex(6, 0);
    chk_log("R7 general call write");
    rst_scn(1'b1); set_tar(13'h0800);
    push(11'h300); settle();
    chk_log("R7 general call read"); chk("R7 gc read cause", abrt_src, 17'h00020);
    rst_scn(1'b1); set_tar(13'h0800); nack_at = 2;
    push(11'h277); settle();
    ex(1, 0); ex(2, 8'h00); ex(6, 0);
    chk_log("R7 gc nack phases"); chk("R7 gc nack cause", abrt_src, 17'h00010);

    // START byte preamble
    rst_scn(1'b1); set_tar(13'h0C33); nack_at = 2;
    push(11'h244); settle();
    ex(1, 0); ex(2, 8'h01); ex(3, 0); ex(2, 8'h66); ex(4, 8'h44); ex(6, 0);
    chk_log("R8 start byte sequence"); chk("R8 start byte ok", abrt_src, 0);
    rst_scn(1'b1); set_tar(13'h0C33);
    push(11'h244); settle();
    ex(1, 0); ex(2, 8'h01); ex(6, 0);
    chk_log("R8 start byte acked"); chk("R8 acked cause", abrt_src, 17'h00080);

    // missing acknowledges
    rst_scn(1'b1); set_tar(13'h0012); nack_at = 2;
    push(11'h201); settle();
    ex(1, 0); ex(2, 8'h24); ex(6, 0);
    chk_log("R9 addr7 nack"); chk("R9 addr7 cause", abrt_src, 17'h00001);
    rst_scn(1'b1); set_tar(13'h0012); nack_at = 3;
    push(11'h201); push(11'h202); settle();
    ex(1, 0); ex(2, 8'h24); ex(4, 8'h01); ex(6, 0);
    chk_log("R9 data nack, rest dropped"); chk("R9 data cause", abrt_src, 17'h00008);
    rst_scn(1'b1); set_tar(13'h12A5); nack_at = 2;
    push(11'h201); settle();
    chk("R9 ten-bit first cause", abrt_src, 17'h00002);
    rst_scn(1'b1); set_tar(13'h12A5); nack_at = 3;
    push(11'h201); settle();
    chk("R9 ten-bit second cause", abrt_src, 17'h00004);
    rst_scn(1'b1); set_tar(13'h12A5); nack_at = 5;
    push(11'h300); settle();
    chk("R9 ten-bit third cause", abrt_src, 17'h00002);

    // arbitration lost
    rst_scn(1'b1); set_tar(13'h0012); arb_at = 3;
    push(11'h201); settle();
    ex(1, 0); ex(2, 8'h24); ex(4, 8'h01);
    chk_log("R10 arb lost no stop"); chk("R10 arb cause", abrt_src, 17'h01000);

    // software abort, flush and clear
    rst_scn(1'b1); set_tar(13'h0012);
    push(11'h011); settle();
    @(negedge clk); abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    chk("R11 pending raised", abort_pending, 1);
    settle();
    chk("R11 pending self-cleared", abort_pending, 0);
    chk("R11 user cause", abrt_src, 17'h10000);
    ex(1, 0); ex(2, 8'h24); ex(4, 8'h11); ex(6, 0);
    chk_log("R11 stop issued");
    push(11'h2AA); push(11'h1BB); settle();
    chk_log("R12 commands dropped");
    pulse_clr();
    chk("R12 clear zeroes source", abrt_src, 0);
    push(11'h2CC); settle();
    ex(1, 0); ex(2, 8'h24); ex(4, 8'hCC); ex(6, 0);
    chk_log("R12 resume after clear");

    // receive back-pressure
    rst_scn(1'b1); set_tar(13'h0012); rx_ready = 1'b0;
    push(11'h300); repeat (30) @(negedge clk);
    chk("R4 rx held valid", rx_valid, 1);
    chk("R4 rx held data", rx_data, 8'h5A ^ 8'd2);
    ex(1, 0); ex(2, 8'h25); ex(5, 0);
    chk_log("R4 no stop while byte waits");
    rx_ready = 1'b1; settle();
    ex(6, 0);
    chk_log("R4 stop after accept");

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule